// File: doc/BRIEF.md
# Shuffle-Exchange Connection Network

This block links four ports through two stages of 2x2 switching elements. Each element is either straight or exchanged, and a fixed perfect-shuffle wiring feeds each stage. Four data words enter on `data_i`. They leave on `data_o` in whatever order the current element settings produce. Every output always carries some input, including outputs that no connection owns.

Connections are added one at a time through a request port that carries a source, a destination and a rearrange flag. The response comes one cycle later as accept or blocked.

- In normal mode, a request is taken in either of two cases. The first is that the current settings already route the source to the destination. The second is that none of the elements on its path is committed yet.
- In rearrange mode, the block computes the settings again for every live connection plus the new one. It accepts the request when no element is asked for two different settings.

A clear command drops all connections and returns every element to straight and uncommitted. Each source-to-destination pair has exactly one path, so rearranging never flips an element that is in use. What it adds is the use of committed elements whose setting already matches.

The response logic is a three-state machine:

| State | Meaning |
|---|---|
| `RSP_IDLE` | No response |
| `RSP_ACCEPT` | Accept pulse |
| `RSP_BLOCK` | Blocked pulse |

From any state, the next state is chosen as follows:

| Condition at the clock edge | Next state |
|---|---|
| Clear asserted | `RSP_IDLE` |
| Request valid and the decision succeeds | `RSP_ACCEPT` |
| Request valid and the decision fails | `RSP_BLOCK` |
| No request | `RSP_IDLE` |

Top module: `shuffle_xnet`

## Requirements
- R1: After reset no response is signalled, `valid_o` is all zero, and every element is straight (setting 0), so output d carries input d.
- R2: Routing follows this rule, with setting 0 = straight and 1 = exchange. Source s = {s1,s0} passes stage-0 element s0, which has setting x0. It then reaches stage-1 element h = s1^x0, which has setting x1. It leaves on output {h, s0^x1}. This holds for every source, whether or not a connection owns the output.
- R3: `valid_o[d]` is 1 exactly when a live connection ends at d, and then `data_o` word d equals the `data_i` word of that connection's source.
- R4: A request sampled at a clock edge gives a response in the following cycle only: either `resp_accept_o` or `resp_blocked_o` is high for that one cycle. With no request, both stay low.
- R5: A request whose source is already live, or whose destination is already owned, is blocked.
- R6: In normal mode, a path s→d needs stage-0 element s0 set to s1^d1 and stage-1 element d1 set to s0^d0. The request is accepted if both elements already hold those settings, or if neither is committed. Otherwise it is blocked. Example: with 0→3 and 3→0 live, 1→1 is blocked. With only 0→0 live, 2→3 is blocked.
- R7: On accept, both path elements take the required settings and become committed. A committed element keeps its setting and its committed state until a clear.
- R8: In rearrange mode, a request is accepted if no committed element needs a different setting, and blocked otherwise. Example: with only 0→0 live, 2→3 is accepted. With 0→3 and 3→0 live, 1→1 is still blocked.
- R9: A blocked request leaves the connections, the settings and therefore `data_o` and `valid_o` unchanged.
- R10: Clear removes all connections and all commits and sets every element straight. Clear takes priority over a request in the same cycle, which then gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clear_i | input | 1 | Drop all connections |
| req_valid_i | input | 1 | Connection request strobe |
| req_src_i | input | IW | Requested source port |
| req_dst_i | input | IW | Requested destination port |
| rearrange_i | input | 1 | Allow recomputation of the settings |
| resp_accept_o | output | 1 | Request accepted (one cycle) |
| resp_blocked_o | output | 1 | Request blocked (one cycle) |
| data_i | input | PORTS*W | Input words, port p at bits p*W +: W |
| data_o | output | PORTS*W | Routed output words |
| valid_o | output | PORTS | Output owned by a live connection |

## Verification
A request is driven at a falling edge and captured at the next rising edge. The accept or blocked pulse, the new ownership and the new element settings all appear after that single register stage. Because `data_o` follows the settings combinationally, the new routing is already visible in the response cycle. The bench therefore reads the response, `valid_o` and every `data_o` word at the falling edge one cycle after the request, and confirms in directed cases that the pulse is gone one cycle later. Expected routing for all four outputs, including outputs no connection owns, comes from a bench model of the settings and the R2 formula.

// File: rtl/xnet_pkg.sv
`timescale 1ns/1ps
package xnet_pkg;

    typedef enum logic [1:0] {
        RSP_IDLE   = 2'd0,
        RSP_ACCEPT = 2'd1,
        RSP_BLOCK  = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/xnet_stage.sv
`timescale 1ns/1ps
// One stage: fixed shuffle wiring followed by a column of 2x2 elements.
module xnet_stage #(
    parameter int PORTS = 4,
    parameter int W     = 8
) (
    input  logic [PORTS*W-1:0]   d_i,
    input  logic [PORTS/2-1:0]   x_i,
    output logic [PORTS*W-1:0]   d_o
);
    localparam int IW    = $clog2(PORTS);
    localparam int ELEMS = PORTS / 2;

    logic [PORTS-1:0][W-1:0] shuf;

    // Shuffle: line p moves to line rotl(p)
    for (genvar p = 0; p < PORTS; p++) begin : g_shuf
        localparam int TO = ((p << 1) | (p >> (IW - 1))) & (PORTS - 1);
        assign shuf[TO] = d_i[p*W +: W];
    end

    // Elements: straight passes 2e+k to 2e+k, exchange swaps the pair
    for (genvar e = 0; e < ELEMS; e++) begin : g_elem
        for (genvar k = 0; k < 2; k++) begin : g_leg
            assign d_o[(2*e+k)*W +: W] = x_i[e] ? shuf[2*e + (1-k)] : shuf[2*e + k];
        end
    end

endmodule

// File: rtl/xnet_decide.sv
`timescale 1ns/1ps
// Accept/blocked decision and the settings that follow an accept.
module xnet_decide #(
    parameter int PORTS = 4
) (
    input  logic [PORTS-1:0]                                  live_i,
    input  logic [PORTS-1:0][$clog2(PORTS)-1:0]               dst_i,
    input  logic [PORTS-1:0]                                  owned_i,
    input  logic [$clog2(PORTS)-1:0][PORTS/2-1:0]             sw_i,
    input  logic [$clog2(PORTS)-1:0][PORTS/2-1:0]             cm_i,
    input  logic [$clog2(PORTS)-1:0]                          src_i,
    input  logic [$clog2(PORTS)-1:0]                          dst_req_i,
    input  logic                                              rearrange_i,
    output logic                                              ok_o,
    output logic [$clog2(PORTS)-1:0][PORTS/2-1:0]             sw_o,
    output logic [$clog2(PORTS)-1:0][PORTS/2-1:0]             cm_o
);
    localparam int IW     = $clog2(PORTS);
    localparam int STAGES = IW;
    localparam int EIW    = IW - 1;

    function automatic logic [IW-1:0] rotl(input logic [IW-1:0] v);
        return {v[IW-2:0], v[IW-1]};
    endfunction

    logic [STAGES-1:0][EIW-1:0] pel;
    logic [STAGES-1:0]          pval;
    logic                       path_exists, path_free, port_clash;
    logic [STAGES-1:0][PORTS/2-1:0] rq_set, rq_val;
    logic                       clash;

    // Path of the requested connection
    always_comb begin : c_path
        logic [IW-1:0] pp;
        pp = src_i;
        pel = '0;
        pval = '0;
        for (int k = 0; k < STAGES; k++) begin
            pp      = rotl(pp);
            pel[k]  = pp[IW-1:1];
            pval[k] = pp[0] ^ dst_req_i[IW-1-k];
            pp[0]   = dst_req_i[IW-1-k];
        end
    end

    always_comb begin : c_normal
        path_exists = 1'b1;
        path_free   = 1'b1;
        for (int k = 0; k < STAGES; k++) begin
            if (sw_i[k][pel[k]] != pval[k]) path_exists = 1'b0;
            if (cm_i[k][pel[k]])             path_free   = 1'b0;
        end
        port_clash = live_i[src_i] | owned_i[dst_req_i];
    end

    // Full recomputation over live connections plus the new one
    always_comb begin : c_rearr
        logic [IW-1:0]  q;
        logic [IW-1:0]  tgt;
        logic [EIW-1:0] e;
        logic           v;
        logic           use_c;
        rq_set = '0;
        rq_val = '0;
        clash  = 1'b0;
        for (int c = 0; c < PORTS; c++) begin
            use_c = (IW'(c) == src_i) ? 1'b1 : live_i[c];
            tgt   = (IW'(c) == src_i) ? dst_req_i : dst_i[c];
            q     = IW'(c);
            for (int k = 0; k < STAGES; k++) begin
                q = rotl(q);
                e = q[IW-1:1];
                v = q[0] ^ tgt[IW-1-k];
                q[0] = tgt[IW-1-k];
                if (use_c) begin
                    if (rq_set[k][e] && (rq_val[k][e] != v)) clash = 1'b1;
                    rq_set[k][e] = 1'b1;
                    rq_val[k][e] = v;
                end
            end
        end
    end

    always_comb begin : c_out
        sw_o = sw_i;
        cm_o = cm_i;
        if (rearrange_i) begin
            ok_o = !port_clash && !clash;
            for (int k = 0; k < STAGES; k++) begin
                for (int j = 0; j < PORTS/2; j++) begin
                    if (rq_set[k][j]) sw_o[k][j] = rq_val[k][j];
                end
            end
            cm_o = cm_i | rq_set;
        end else begin
            ok_o = !port_clash && (path_exists || path_free);
            for (int k = 0; k < STAGES; k++) begin
                sw_o[k][pel[k]] = pval[k];
                cm_o[k][pel[k]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/shuffle_xnet.sv
`timescale 1ns/1ps
module shuffle_xnet
    import xnet_pkg::*;
#(
    parameter int PORTS = 4,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear_i,
    input  logic                       req_valid_i,
    input  logic [$clog2(PORTS)-1:0]   req_src_i,
    input  logic [$clog2(PORTS)-1:0]   req_dst_i,
    input  logic                       rearrange_i,
    output logic                       resp_accept_o,
    output logic                       resp_blocked_o,
    input  logic [PORTS*W-1:0]         data_i,
    output logic [PORTS*W-1:0]         data_o,
    output logic [PORTS-1:0]           valid_o
);
    localparam int IW     = $clog2(PORTS);
    localparam int STAGES = IW;
    localparam int ELEMS  = PORTS / 2;

    rsp_state_e st_q, st_d;

    logic [STAGES-1:0][ELEMS-1:0] sw_q, cm_q, sw_nx, cm_nx;
    logic [PORTS-1:0]             live_q;
    logic [PORTS-1:0][IW-1:0]     dst_q;
    logic [PORTS-1:0]             owned;
    logic [PORTS-1:0][IW-1:0]     owner;
    logic                         dec_ok;
    logic                         take;

    // Ownership of each destination
    always_comb begin
        owned = '0;
        owner = '0;
        for (int s = 0; s < PORTS; s++) begin
            if (live_q[s]) begin
                owned[dst_q[s]] = 1'b1;
                owner[dst_q[s]] = IW'(s);
            end
        end
    end

    xnet_decide #(.PORTS(PORTS)) u_decide (
        .live_i      (live_q),
        .dst_i       (dst_q),
        .owned_i     (owned),
        .sw_i        (sw_q),
        .cm_i        (cm_q),
        .src_i       (req_src_i),
        .dst_req_i   (req_dst_i),
        .rearrange_i (rearrange_i),
        .ok_o        (dec_ok),
        .sw_o        (sw_nx),
        .cm_o        (cm_nx)
    );

    assign take = req_valid_i && !clear_i && dec_ok;

    // Connection table and element settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
            dst_q  <= '0;
            sw_q   <= '0;
            cm_q   <= '0;
        end else if (clear_i) begin
            live_q <= '0;
            dst_q  <= '0;
            sw_q   <= '0;
            cm_q   <= '0;
        end else if (take) begin
            live_q[req_src_i] <= 1'b1;
            dst_q[req_src_i]  <= req_dst_i;
            sw_q <= sw_nx;
            cm_q <= cm_nx;
        end
    end

    // Response state machine: next state
    always_comb begin
        st_d = RSP_IDLE;
        if (!clear_i && req_valid_i) st_d = dec_ok ? RSP_ACCEPT : RSP_BLOCK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RSP_IDLE;
        else        st_q <= st_d;
    end

    // Response state machine: outputs
    always_comb begin
        resp_accept_o  = 1'b0;
        resp_blocked_o = 1'b0;
        unique case (st_q)
            RSP_IDLE:   ;
            RSP_ACCEPT: resp_accept_o  = 1'b1;
            RSP_BLOCK:  resp_blocked_o = 1'b1;
            default:    ;
        endcase
    end

    // Datapath
    logic [STAGES:0][PORTS*W-1:0] lane;
    assign lane[0] = data_i;
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        xnet_stage #(.PORTS(PORTS), .W(W)) u_stg (
            .d_i (lane[g]),
            .x_i (sw_q[g]),
            .d_o (lane[g+1])
        );
    end
    assign data_o  = lane[STAGES];
    assign valid_o = owned;

    // R3
    for (genvar d = 0; d < PORTS; d++) begin : g_route_chk
        owned_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o[d] |-> data_o[d*W +: W] == data_i[owner[d]*W +: W]);
    end

    // R4
    resp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_accept_o || resp_blocked_o) |-> $past(req_valid_i && !clear_i));

    // R4
    resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid_i) |-> !(resp_accept_o || resp_blocked_o));

    // R7
    commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear_i) |-> ((cm_q & $past(cm_q)) == $past(cm_q)));

    // R7
    setting_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear_i) |-> (((sw_q ^ $past(sw_q)) & $past(cm_q)) == '0));

    // R9
    blocked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_blocked_o |-> (live_q == $past(live_q)) && (sw_q == $past(sw_q)));

    // R10
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear_i) |-> (live_q == '0) && (cm_q == '0) && !resp_accept_o && !resp_blocked_o);

endmodule

// File: tb/shuffle_xnet_bench.sv
`timescale 1ns/1ps
module shuffle_xnet_bench;
    localparam int W = 8;
    localparam int PORTS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_i = 1'b0;
    logic req_valid_i = 1'b0;
    logic rearrange_i = 1'b0;
    logic [1:0] req_src_i = '0;
    logic [1:0] req_dst_i = '0;
    logic [PORTS*W-1:0] data_i = '0;
    logic [PORTS*W-1:0] data_o;
    logic [PORTS-1:0]   valid_o;
    logic resp_accept_o, resp_blocked_o;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    int m_live [4];
    int m_dst  [4];
    int m_sw   [2][2];
    int m_cm   [2][2];

    always #2.5 clk = ~clk; // 200 MHz

    shuffle_xnet #(.PORTS(PORTS), .W(W)) u_shuffle_xnet (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .req_valid_i(req_valid_i),
        .req_src_i(req_src_i), .req_dst_i(req_dst_i), .rearrange_i(rearrange_i),
        .resp_accept_o(resp_accept_o), .resp_blocked_o(resp_blocked_o),
        .data_i(data_i), .data_o(data_o), .valid_o(valid_o)
    );

    task automatic check(bit cond, string req, string what, int act, int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_live[i] = 0;
            m_dst[i] = 0;
        end
        for (int k = 0; k < 2; k++)
            for (int e = 0; e < 2; e++) begin
                m_sw[k][e] = 0;
                m_cm[k][e] = 0;
            end
    endtask

    function automatic int model_valid();
        int v = 0;
        for (int s = 0; s < 4; s++) if (m_live[s] != 0) v |= (1 << m_dst[s]);
        return v;
    endfunction

    // R2 / R3: valid vector and routing of every output
    task automatic check_outputs(string req);
        check(valid_o == 4'(model_valid()), req, "valid_o (R3)", int'(valid_o), model_valid());
        for (int s = 0; s < 4; s++) begin
            int s0 = s & 1;
            int s1 = (s >> 1) & 1;
            int hi = s1 ^ m_sw[0][s0];
            int d  = hi * 2 + (s0 ^ m_sw[1][hi]);
            check(data_o[d*W +: W] == data_i[s*W +: W], req, "data_o word (R2)",
                  int'(data_o[d*W +: W]), int'(data_i[s*W +: W]));
        end
    endtask

    function automatic bit model_decide(int s, int d, bit rr);
        int e0 = s & 1;
        int v0 = ((s >> 1) ^ (d >> 1)) & 1;
        int e1 = (d >> 1) & 1;
        int v1 = (s ^ d) & 1;
        bit conflict = (m_live[s] != 0) || ((model_valid() >> d) & 1) != 0;
        if (conflict) return 1'b0;
        if (rr)
            return ((m_cm[0][e0] == 0) || (m_sw[0][e0] == v0)) &&
                   ((m_cm[1][e1] == 0) || (m_sw[1][e1] == v1));
        return ((m_sw[0][e0] == v0) && (m_sw[1][e1] == v1)) ||
               ((m_cm[0][e0] == 0) && (m_cm[1][e1] == 0));
    endfunction

    task automatic model_apply(int s, int d);
        int e0 = s & 1;
        int e1 = (d >> 1) & 1;
        m_sw[0][e0] = ((s >> 1) ^ (d >> 1)) & 1;
        m_sw[1][e1] = (s ^ d) & 1;
        m_cm[0][e0] = 1;
        m_cm[1][e1] = 1;
        m_live[s] = 1;
        m_dst[s] = d;
    endtask

    // want: 1 accept, 0 blocked, -1 take the model's answer
    task automatic do_req(int s, int d, bit rr, int want, string req);
        bit exp;
        exp = (want < 0) ? model_decide(s, d, rr) : bit'(want);
        data_i = {$urandom};
        req_src_i = 2'(s);
        req_dst_i = 2'(d);
        rearrange_i = rr;
        req_valid_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
        check(resp_accept_o == exp, req, "resp_accept_o (R4)", int'(resp_accept_o), int'(exp));
        check(resp_blocked_o == !exp, req, "resp_blocked_o (R4)", int'(resp_blocked_o), int'(!exp));
        if (exp) model_apply(s, d);
        check_outputs(req);
    endtask

    task automatic check_idle(string req);
        @(negedge clk);
        check(!resp_accept_o && !resp_blocked_o, req, "response after one cycle",
              int'({resp_accept_o, resp_blocked_o}), 0);
    endtask

    task automatic do_clear(bit with_req);
        clear_i = 1'b1;
        if (with_req) begin
            req_src_i = 2'd2;
            req_dst_i = 2'd1;
            rearrange_i = 1'b0;
            req_valid_i = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        clear_i = 1'b0;
        req_valid_i = 1'b0;
        model_reset();
        check(!resp_accept_o && !resp_blocked_o, "R10", "response after clear",
              int'({resp_accept_o, resp_blocked_o}), 0);
        check_outputs("R10");
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd1907);
        model_reset();
        data_i = {$urandom};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!resp_accept_o && !resp_blocked_o, "R1", "response at reset",
              int'({resp_accept_o, resp_blocked_o}), 0);
        check_outputs("R1");

        // R6 free path, R4 single pulse
        do_req(0, 3, 1'b0, 1, "R6");
        check_idle("R4");
        do_req(3, 0, 1'b0, 1, "R6");
        // R6 blocked example, R9 nothing changes
        do_req(1, 1, 1'b0, 0, "R6");
        check_outputs("R9");
        // R8 true conflict stays blocked
        do_req(1, 1, 1'b1, 0, "R8");
        // R5 port conflicts
        do_req(0, 2, 1'b0, 0, "R5");
        do_req(2, 3, 1'b1, 0, "R5");

        do_clear(1'b0);
        do_req(0, 0, 1'b0, 1, "R7");
        do_req(2, 3, 1'b0, 0, "R6");
        do_req(2, 3, 1'b1, 1, "R8");
        // R7 settings held: earlier path still routed
        check_outputs("R7");
        do_clear(1'b1);

        for (int i = 0; i < 400; i++) begin
            if (($urandom % 8) == 0) do_clear(bit'($urandom % 2));
            else do_req(int'($urandom % 4), int'($urandom % 4), bit'($urandom % 2), -1, "R6 R8 random");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule